// File: doc/BRIEF.md
# I2C Channel Select Switch Controller

This block is the digital control half of a two-way bus switch. It acts as an I2C target on an upstream bus, oversampling SCL and SDA with the system clock. It holds a small selection register and drives two channel-enable outputs that would close the pass gates toward two downstream bus segments. Software on the upstream master addresses the block, writes a byte whose two low bits pick the channels, and ends with a stop. The new selection reaches the enable outputs only at that stop, so a segment is never attached while a transfer is still running on the upstream lines.

A read of the block returns one status byte. It carries the current channel selection together with the live level of two active-low interrupt inputs, one for each downstream segment, so the master can find which segment raised an interrupt. SDA is handled in open-drain fashion. The block only asserts a pull-low enable and never drives the line high. An active-low reset input recovers the block from a stuck bus. It clears the selection and returns the protocol engine to idle.

Top module: `i2c_chan_switch`

## Requirements
- R1: While reset is held low, and after it is released, both channel enables are 0 and the SDA pull-low enable is 0.
- R2: The block responds only to the 7-bit address whose upper five bits are 11100, bit 1 is strap input bit 1 and bit 0 is strap input bit 0. The eighth bit selects a read (1) or a write (0). An address match is acknowledged by pulling SDA low for the ninth clock.
- R3: On a write, each data byte is acknowledged. Bit 0 of the byte enables channel 0 and bit 1 enables channel 1. Any combination, including both or neither, is allowed. When several bytes arrive in one transaction, only the last one is kept.
- R4: A written selection does not change the channel enables until a stop condition (SDA rising while SCL is high) is seen. At the stop, the enables take the kept value.
- R5: A read returns a byte with bit 5 = 1 when interrupt input 1 is low and bit 4 = 1 when interrupt input 0 is low. Bits 1:0 hold the active channel selection, and all other bits are 0. The byte is sent MSB first.
- R6: If the master acknowledges a read byte, another status byte follows. If the master does not acknowledge, the block releases SDA and drives nothing more until the next start.
- R7: A start condition (SDA falling while SCL is high) seen in the middle of a transaction restarts address reception.
- R8: After a non-matching address the block does not acknowledge or store anything until the next start.
- R9: A pulse on SCL or SDA that lasts fewer than FILT_CYC clock cycles after synchronization is ignored.
- R10: Asserting reset in the middle of a transaction clears the selection, drops both enables, releases SDA and discards any pending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_strap_i | input | 2 | Strap inputs forming the two low address bits |
| irq_n_i | input | 2 | Active-low interrupt inputs, one per downstream channel |
| scl_i | input | 1 | Upstream serial clock level |
| sda_i | input | 1 | Upstream serial data level as seen on the wire |
| sda_pull_o | output | 1 | When 1, the SDA line is pulled low |
| chan_en_o | output | 2 | Enable for each downstream channel, bit n for channel n |

## Verification
The bench builds the block with FILT_CYC = 4 and the default two-stage synchronizer. A bus quarter-period of 25 clocks leaves ample margin over the roughly seven cycles of input latency. A two-cycle SCL spike injected into an address bit lies inside the rejection window, so the spike filter's effect shows up as a correct or a broken acknowledge. Randomized transactions mix matching and non-matching addresses, one to three data bytes and changing interrupt levels. Directed cases cover the hold-until-stop rule, repeated start, read continuation and termination, and a reset landing during an acknowledge.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int CH_N    = 2;
  localparam int IRQ_LSB = 4;
  localparam int BYTE_W  = 8;
  localparam logic [4:0] ADDR_HI = 5'b11100;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK, ST_IGN
  } i2cs_state_e;
endpackage

// File: rtl/i2cs_glitch_filter.sv
module i2cs_glitch_filter #(
  parameter int SYNC_LEN = 2,
  parameter int FILT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(FILT_CYC - 1);

  logic [SYNC_LEN-1:0] sync_q;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic                out_q, out_d;
  logic                sync_bit;

  assign sync_bit = sync_q[SYNC_LEN-1];

  always_comb begin
    cnt_d = '0;
    out_d = out_q;
    if (sync_bit != out_q) begin
      if (cnt_q == LIM) out_d = sync_bit;
      else              cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], line_i};
      cnt_q  <= cnt_d;
      out_q  <= out_d;
    end
  end

  assign line_o = out_q;

  // R9
  hold_when_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_bit == out_q) |=> $stable(out_q));
endmodule

// File: rtl/i2cs_target_fsm.sv
module i2cs_target_fsm
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic [1:0]        strap_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_byte_o,
  output logic              stop_o,
  output logic              sda_pull_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  i2cs_state_e       st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              scl_q, sda_q, pull_q, pull_d, rw_q, rw_d;
  logic              scl_rise, scl_fall, start_c, stop_c;

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    pull_d = pull_q;
    rw_d   = rw_q;
    if (start_c) begin
      st_d = ST_ADDR; cnt_d = '0; pull_d = 1'b0;
    end else if (stop_c) begin
      st_d = ST_IDLE; pull_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_WDAT: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_f};
            cnt_d = cnt_q + 1'b1;
          end
          if (scl_fall && cnt_q == LAST) begin
            if (st_q == ST_WDAT) begin
              st_d = ST_WACK; pull_d = 1'b1;
            end else if (sh_q[7:1] == {ADDR_HI, strap_i}) begin
              st_d = ST_AACK; pull_d = 1'b1; rw_d = sh_q[0];
            end else begin
              st_d = ST_IGN;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          cnt_d = '0;
          if (rw_q) begin
            st_d = ST_RDAT; sh_d = status_i; pull_d = ~status_i[BYTE_W-1];
          end else begin
            st_d = ST_WDAT; pull_d = 1'b0;
          end
        end
        ST_WACK: if (scl_fall) begin
          st_d = ST_WDAT; cnt_d = '0; pull_d = 1'b0;
        end
        ST_RDAT: if (scl_fall) begin
          sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST - 1'b1) begin
            st_d = ST_RACK; pull_d = 1'b0;
          end else begin
            pull_d = ~sh_q[BYTE_W-2];
          end
        end
        ST_RACK: begin
          if (scl_rise && sda_f) st_d = ST_IGN;
          else if (scl_fall) begin
            st_d = ST_RDAT; cnt_d = '0; sh_d = status_i;
            pull_d = ~status_i[BYTE_W-1];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      pull_q <= 1'b0;
      rw_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      scl_q  <= scl_f;
      sda_q  <= sda_f;
      pull_q <= pull_d;
      rw_q   <= rw_d;
    end
  end

  assign wr_valid_o = (st_q == ST_WDAT) && scl_fall && (cnt_q == LAST) && !start_c && !stop_c;
  assign wr_byte_o  = sh_q;
  assign stop_o     = stop_c;
  assign sda_pull_o = pull_q;

  // R2
  pull_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pull_q |-> (st_q == ST_AACK || st_q == ST_WACK || st_q == ST_RDAT));
  // R8
  ign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IGN) |-> !pull_q);
  // R6
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RACK && scl_rise && sda_f) |=> (st_q == ST_IGN && !pull_q));
  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (st_q == ST_ADDR && cnt_q == '0 && !pull_q));
endmodule

// File: rtl/i2c_chan_switch.sv
module i2c_chan_switch
  import i2cs_pkg::*;
#(
  parameter int FILT_CYC = 4,
  parameter int SYNC_LEN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      addr_strap_i,
  input  logic [CH_N-1:0] irq_n_i,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_pull_o,
  output logic [CH_N-1:0] chan_en_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_n_s;
  logic [1:0]        line_raw, line_flt;
  logic [CH_N-1:0]   irq_s1_q, irq_s2_q;
  logic [CH_N-1:0]   pend_q, pend_d, act_q, act_d;
  logic              pvld_q, pvld_d;
  logic [BYTE_W-1:0] status, wr_byte;
  logic              wr_valid, stop_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  assign line_raw = {sda_i, scl_i};
  for (genvar g = 0; g < 2; g++) begin : g_flt
    i2cs_glitch_filter #(.SYNC_LEN(SYNC_LEN), .FILT_CYC(FILT_CYC)) flt_i (
      .clk(clk), .rst_n(rst_n_s), .line_i(line_raw[g]), .line_o(line_flt[g]));
  end

  always_comb begin
    status = '0;
    status[IRQ_LSB +: CH_N] = ~irq_s2_q;
    status[CH_N-1:0]        = act_q;
  end

  i2cs_target_fsm fsm_i (
    .clk(clk), .rst_n(rst_n_s), .scl_f(line_flt[0]), .sda_f(line_flt[1]),
    .strap_i(addr_strap_i), .status_i(status), .wr_valid_o(wr_valid),
    .wr_byte_o(wr_byte), .stop_o(stop_p), .sda_pull_o(sda_pull_o));

  always_comb begin
    pend_d = pend_q;
    pvld_d = pvld_q;
    act_d  = act_q;
    if (wr_valid) begin
      pend_d = wr_byte[CH_N-1:0];
      pvld_d = 1'b1;
    end else if (stop_p && pvld_q) begin
      act_d  = pend_q;
      pvld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      irq_s1_q <= '1;
      irq_s2_q <= '1;
      pend_q   <= '0;
      pvld_q   <= 1'b0;
      act_q    <= '0;
    end else begin
      irq_s1_q <= irq_n_i;
      irq_s2_q <= irq_s1_q;
      pend_q   <= pend_d;
      pvld_q   <= pvld_d;
      act_q    <= act_d;
    end
  end

  assign chan_en_o = act_q;

  // R4
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !stop_p |=> $stable(act_q));
  // R3
  pend_load_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_valid |=> (pvld_q && pend_q == $past(wr_byte[CH_N-1:0])));
endmodule

// File: tb/i2c_chan_switch_tb_top.sv
module i2c_chan_switch_tb_top;
  localparam int Q = 25;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] strap = 2'b10;
  logic [1:0] irq_n = 2'b11;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pull;
  logic [1:0] chan_en;
  wire  sda_bus = m_sda & ~sda_pull;
  int   errors = 0, checks = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_chan_switch #(.FILT_CYC(4), .SYNC_LEN(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_strap_i(strap), .irq_n_i(irq_n),
    .scl_i(m_scl), .sda_i(sda_bus), .sda_pull_o(sda_pull), .chan_en_o(chan_en));

  function automatic logic [7:0] exp_status(logic [1:0] act, logic [1:0] irqn);
    return {2'b00, ~irqn[1], ~irqn[0], 2'b00, act};
  endfunction

  task automatic wcyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wcyc(Q); m_scl = 1'b1; wcyc(2*Q);
    m_sda = 1'b0; wcyc(2*Q); m_scl = 1'b0; wcyc(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wcyc(Q); m_scl = 1'b1; wcyc(2*Q);
    m_sda = 1'b1; wcyc(2*Q);
  endtask

  task automatic bit_out(logic b, output logic seen);
    m_sda = b; wcyc(Q); m_scl = 1'b1; wcyc(Q);
    seen = sda_bus; wcyc(Q); m_scl = 1'b0; wcyc(Q);
  endtask

  task automatic write_byte(logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_out(d[i], s);
    bit_out(1'b1, s);
    ack = ~s;
  endtask

  task automatic read_byte(logic master_ack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_out(1'b1, s);
      v[i] = s;
    end
    bit_out(~master_ack, s);
  endtask

  task automatic do_read(logic [1:0] st, output logic [7:0] v);
    logic ack;
    i2c_start();
    write_byte({5'b11100, st, 1'b1}, ack);
    read_byte(1'b0, v);
    i2c_stop();
  endtask

  initial begin
    logic ack, s;
    logic [7:0] v, d;
    logic [1:0] model_act, last;
    logic match;
    int nb;
    void'($urandom(32'd2468));
    wcyc(5);
    // R1: state during reset
    check("R1 pull in reset", {31'd0, sda_pull}, 0);
    check("R1 chan in reset", {30'd0, chan_en}, 0);
    rst_n = 1'b1; wcyc(20);
    check("R1 chan after reset", {30'd0, chan_en}, 0);
    model_act = 2'b00;

    // R3/R4: two bytes, last kept, applied only at stop
    i2c_start();
    write_byte({5'b11100, strap, 1'b0}, ack); check("R2 addr ack", {31'd0, ack}, 1);
    write_byte(8'hF2, ack); check("R3 byte1 ack", {31'd0, ack}, 1);
    write_byte(8'h03, ack); check("R3 byte2 ack", {31'd0, ack}, 1);
    check("R4 held before stop", {30'd0, chan_en}, 0);
    i2c_stop();
    model_act = 2'b11;
    check("R4 applied at stop", {30'd0, chan_en}, 32'(model_act));

    // R5/R6: read, master acks once then nacks
    irq_n = 2'b01; wcyc(10);
    i2c_start();
    write_byte({5'b11100, strap, 1'b1}, ack); check("R2 read addr ack", {31'd0, ack}, 1);
    read_byte(1'b1, v); check("R5 status byte", {24'd0, v}, 32'(exp_status(model_act, irq_n)));
    read_byte(1'b0, v); check("R6 second byte after ack", {24'd0, v}, 32'(exp_status(model_act, irq_n)));
    bit_out(1'b1, s); check("R6 released after nack", {31'd0, s}, 1);
    check("R6 no pull after nack", {31'd0, sda_pull}, 0);
    i2c_stop();
    irq_n = 2'b11;

    // R8: non-matching address, data ignored
    i2c_start();
    write_byte({5'b11100, ~strap, 1'b0}, ack); check("R8 no ack wrong addr", {31'd0, ack}, 0);
    write_byte(8'h00, ack); check("R8 data not acked", {31'd0, ack}, 0);
    i2c_stop();
    check("R8 sel unchanged", {30'd0, chan_en}, 32'(model_act));

    // R7: repeated start after a mismatch restarts address reception
    i2c_start();
    write_byte({5'b11100, ~strap, 1'b0}, ack);
    i2c_start();
    write_byte({5'b11100, strap, 1'b0}, ack); check("R7 ack after restart", {31'd0, ack}, 1);
    write_byte(8'h01, ack);
    i2c_stop();
    model_act = 2'b01;
    check("R7 write after restart", {30'd0, chan_en}, 32'(model_act));

    // R9: short SCL spike inside an address bit
    strap = 2'b01; wcyc(10);
    i2c_start();
    m_sda = 1'b1; wcyc(5); m_scl = 1'b1; wcyc(2); m_scl = 1'b0; wcyc(10);
    write_byte({5'b11100, strap, 1'b0}, ack); check("R9 spike ignored", {31'd0, ack}, 1);
    write_byte(8'h02, ack);
    i2c_stop();
    model_act = 2'b10;
    check("R9 write with spike", {30'd0, chan_en}, 32'(model_act));

    // R10: reset while acknowledging a data byte
    i2c_start();
    write_byte({5'b11100, strap, 1'b0}, ack);
    for (int i = 7; i >= 0; i--) bit_out(i == 0, s);
    m_sda = 1'b1; wcyc(Q); m_scl = 1'b1; wcyc(Q);
    check("R2 pull during data ack", {31'd0, sda_pull}, 1);
    rst_n = 1'b0; wcyc(3);
    check("R10 pull released", {31'd0, sda_pull}, 0);
    check("R10 chan cleared", {30'd0, chan_en}, 0);
    rst_n = 1'b1; wcyc(20);
    i2c_stop();
    model_act = 2'b00;
    check("R10 pending discarded", {30'd0, chan_en}, 0);

    // Random transactions (R2, R3, R5, R8)
    for (int t = 0; t < 10; t++) begin
      match = ($urandom % 4) != 0;
      nb = 1 + int'($urandom % 3);
      last = model_act;
      i2c_start();
      write_byte({5'b11100, match ? strap : ~strap, 1'b0}, ack);
      check("R2 random addr ack", {31'd0, ack}, {31'd0, match});
      for (int b = 0; b < nb; b++) begin
        d = 8'($urandom);
        write_byte(d, ack);
        check("R3 random data ack", {31'd0, ack}, {31'd0, match});
        last = d[1:0];
      end
      i2c_stop();
      if (match) model_act = last;
      check("R3 random sel", {30'd0, chan_en}, 32'(model_act));
      irq_n = 2'($urandom); wcyc(10);
      do_read(strap, v);
      check("R5 random status", {24'd0, v}, 32'(exp_status(model_act, irq_n)));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule